// File: doc/BRIEF.md
# Reset Sequencer with Cause Capture

This block gathers the reset requests of a small controller and turns any one of them into a fixed, timed reset sequence. Once a request is accepted, the block pulls an active-low, bidirectional reset pin low for a set number of bus cycles. It then lets go of the pin and waits a second set number of cycles. At the end of that wait it samples the pin. If something outside the chip is still holding the pin low, and pin resets are enabled, the external pin is recorded as a cause of the reset.

The request sources are:
- an illegal-opcode detector,
- a debug-forced reset,
- the external pin itself,
- a clock-loss / loss-of-lock detector,
- a watchdog timeout.

Each source except the debug request owns one bit of a read-only status word. The status word is cleared whenever a new sequence starts, and then holds the causes of that reset. When several sources request at the same time, several bits are set. The internal reset output covers the whole sequence, both the drive phase and the wait phase.

The pin is modelled as two signals: a drive-low enable and a sampled level. The sampled level is taken as already synchronous to `clk`. The clock keeps running during reset. All ports are plain control and status signals, so no valid/ready handshake applies. The status word is a continuous read port with no back-pressure.

Top module: `reset_sequencer`

## Requirements
- R1: While `arst_n` is low and after it is released, `pin_drive_low` and `core_rst` are 0 and `status` is 0 until a request arrives.
- R2: While idle (`core_rst` = 0), a start request raises both `pin_drive_low` and `core_rst` on the next clock edge. A start request is any of `req_illop`, `req_dbg`, `req_clkfail` or `req_wdog` high, or `pin_en` high with `pin_in` low.
- R3: `pin_drive_low` stays high for exactly DRIVE_CYC (default 34) consecutive cycles.
- R4: After the drive phase, `pin_drive_low` is 0 and `core_rst` stays high for SETTLE_CYC (default 38) more cycles. `core_rst` is therefore high for DRIVE_CYC+SETTLE_CYC (default 72) cycles in total.
- R5: On the last cycle of the wait phase the pin is sampled. `status[0]` becomes 1 if `pin_en` is 1 and `pin_in` is 0 at that moment, and 0 otherwise.
- R6: With `pin_en` = 0, a low `pin_in` neither starts a sequence nor sets `status[0]`.
- R7: When a sequence starts, `status` is cleared and then loaded with the sources active in the start cycle. The bit positions are: bit 1 watchdog, bit 2 illegal opcode, bit 3 clock loss. Bit 0 (pin) is cleared and is decided only by the sample of R5. Simultaneous sources set several bits.
- R8: A debug-only request runs the full R3/R4 sequence and leaves `status` at 0.
- R9: Requests that arrive while a sequence is running neither restart its timing nor change `status`.
- R10: While idle, `status` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| arst_n | input | 1 | Asynchronous active-low power-up reset of the block |
| req_illop | input | 1 | Illegal-opcode reset request |
| req_dbg | input | 1 | Debug-forced reset request (no status bit) |
| req_clkfail | input | 1 | Clock loss or loss-of-lock reset request |
| req_wdog | input | 1 | Watchdog timeout reset request |
| pin_en | input | 1 | Enables the external pin as a reset source |
| pin_in | input | 1 | Sampled level of the reset pin (0 = low) |
| pin_drive_low | output | 1 | 1 drives the reset pin low |
| core_rst | output | 1 | Internal reset, high for the whole sequence |
| status | output | 4 | Read-only reset-cause word: bit0 pin, bit1 watchdog, bit2 illegal opcode, bit3 clock loss |

## Verification
The checker watches several properties on every cycle:
- that an idle request starts the sequence on the next edge;
- that the pin drive never lasts beyond DRIVE_CYC cycles and always ends after exactly that many;
- that the internal reset ends after exactly the full sequence length and still covers the moment the drive ends;
- that the status word never moves while idle;
- that the pin bit rises only when an enabled, low pin was seen at the sample point.

The exact contents of the status word can only be shown by the bench's scenarios. These include clearing of a previous pin bit, combinations of simultaneous sources, debug-only resets, the pin released before versus after the sample point, a disabled pin, and requests injected mid-sequence.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int STAT_W   = 4;
  localparam int ST_PIN   = 0;
  localparam int ST_WDOG  = 1;
  localparam int ST_ILLOP = 2;
  localparam int ST_CLK   = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRIVE  = 2'd1,
    PH_SETTLE = 2'd2
  } phase_t;

  // Packed so that bit positions match the status word.
  typedef struct packed {
    logic clkfail;
    logic illop;
    logic wdog;
    logic pin;
  } cause_t;
endpackage

// File: rtl/rstseq_trigger.sv
module rstseq_trigger
  import rstseq_pkg::*;
(
  input  logic   req_illop,
  input  logic   req_dbg,
  input  logic   req_clkfail,
  input  logic   req_wdog,
  input  logic   pin_en,
  input  logic   pin_in,
  output cause_t cause,
  output logic   start
);
  always_comb begin
    cause.pin     = pin_en & ~pin_in;
    cause.wdog    = req_wdog;
    cause.illop   = req_illop;
    cause.clkfail = req_clkfail;
    // Debug request starts a sequence without owning a status bit.
    start         = (|cause) | req_dbg;
  end
endmodule

// File: rtl/rstseq_phase.sv
module rstseq_phase
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYC  = 34,
  parameter int SETTLE_CYC = 38
) (
  input  logic   clk,
  input  logic   arst_n,
  input  logic   start,
  output phase_t phase,
  output logic   sample_now
);
  localparam int LONGEST = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
  localparam int CW      = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam logic [CW-1:0] DRIVE_LAST  = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start) phase <= PH_DRIVE;
        end
        PH_DRIVE: begin
          if (cnt_q == DRIVE_LAST) begin
            phase <= PH_SETTLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SETTLE: begin
          if (cnt_q == SETTLE_LAST) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign sample_now = (phase == PH_SETTLE) && (cnt_q == SETTLE_LAST);
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
  import rstseq_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              accept,
  input  logic              sample_now,
  input  cause_t            cause,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] cause_bits;
  assign cause_bits = cause;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == ST_PIN) begin : g_pin
      // Pin cause is decided only at the end of the wait phase.
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)         status[i] <= 1'b0;
        else if (accept)     status[i] <= 1'b0;
        else if (sample_now) status[i] <= cause_bits[i];
      end
    end else begin : g_req
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     status[i] <= 1'b0;
        else if (accept) status[i] <= cause_bits[i];
      end
    end
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYC  = 34,
  parameter int SETTLE_CYC = 38
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        req_illop,
  input  logic        req_dbg,
  input  logic        req_clkfail,
  input  logic        req_wdog,
  input  logic        pin_en,
  input  logic        pin_in,
  output logic        pin_drive_low,
  output logic        core_rst,
  output logic [3:0]  status
);
  cause_t cause;
  logic   start;
  phase_t phase;
  logic   sample_now;
  logic   accept;

  rstseq_trigger u_trig (
    .req_illop   (req_illop),
    .req_dbg     (req_dbg),
    .req_clkfail (req_clkfail),
    .req_wdog    (req_wdog),
    .pin_en      (pin_en),
    .pin_in      (pin_in),
    .cause       (cause),
    .start       (start)
  );

  rstseq_phase #(
    .DRIVE_CYC  (DRIVE_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_phase (
    .clk        (clk),
    .arst_n     (arst_n),
    .start      (start),
    .phase      (phase),
    .sample_now (sample_now)
  );

  assign accept = start && (phase == PH_IDLE);

  rstseq_status u_stat (
    .clk        (clk),
    .arst_n     (arst_n),
    .accept     (accept),
    .sample_now (sample_now),
    .cause      (cause),
    .status     (status)
  );

  assign pin_drive_low = (phase == PH_DRIVE);
  assign core_rst      = (phase != PH_IDLE);
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk #(
  parameter int DRIVE_CYC  = 34,
  parameter int SETTLE_CYC = 38
) (
  input logic       clk,
  input logic       arst_n,
  input logic       req_illop,
  input logic       req_dbg,
  input logic       req_clkfail,
  input logic       req_wdog,
  input logic       pin_en,
  input logic       pin_in,
  input logic       pin_drive_low,
  input logic       core_rst,
  input logic [3:0] status
);
  localparam int TOTAL = DRIVE_CYC + SETTLE_CYC;

  logic any_req;
  int   drv_cnt;
  int   rst_cnt;

  assign any_req = req_illop | req_dbg | req_clkfail | req_wdog | (pin_en & ~pin_in);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      drv_cnt <= 0;
      rst_cnt <= 0;
    end else begin
      drv_cnt <= pin_drive_low ? drv_cnt + 1 : 0;
      rst_cnt <= core_rst ? rst_cnt + 1 : 0;
    end
  end

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && any_req) |=> (pin_drive_low && core_rst)); // R2

  AST_DRIVE_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    pin_drive_low |-> (drv_cnt < DRIVE_CYC)); // R3

  AST_DRIVE_LEN: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pin_drive_low) |-> ($past(drv_cnt) == DRIVE_CYC - 1)); // R3

  AST_SETTLE_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pin_drive_low) |-> core_rst); // R4

  AST_RST_LEN: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(core_rst) |-> ($past(rst_cnt) == TOTAL - 1)); // R4

  AST_PIN_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(status[0]) |-> $past(pin_en && !pin_in)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && $past(!core_rst)) |-> $stable(status)); // R10
endmodule

bind reset_sequencer reset_sequencer_chk #(
  .DRIVE_CYC  (DRIVE_CYC),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk           (clk),
  .arst_n        (arst_n),
  .req_illop     (req_illop),
  .req_dbg       (req_dbg),
  .req_clkfail   (req_clkfail),
  .req_wdog      (req_wdog),
  .pin_en        (pin_en),
  .pin_in        (pin_in),
  .pin_drive_low (pin_drive_low),
  .core_rst      (core_rst),
  .status        (status)
);

// File: tb/reset_sequencer_test.sv
`timescale 1ns/1ps
module reset_sequencer_test;
  localparam int DRV = 34;
  localparam int SET = 38;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic req_illop = 1'b0, req_dbg = 1'b0, req_clkfail = 1'b0, req_wdog = 1'b0;
  logic pin_en = 1'b0;
  logic ext_low = 1'b0;
  logic pin_in;
  logic pin_drive_low, core_rst;
  logic [3:0] status;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;
  assign pin_in = ~(pin_drive_low | ext_low);

  reset_sequencer uut (
    .clk(clk), .arst_n(arst_n), .req_illop(req_illop), .req_dbg(req_dbg),
    .req_clkfail(req_clkfail), .req_wdog(req_wdog), .pin_en(pin_en),
    .pin_in(pin_in), .pin_drive_low(pin_drive_low), .core_rst(core_rst),
    .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mask bits: 0 pin held low externally, 1 wdog, 2 illop, 3 clock loss, 4 debug
  function automatic logic [3:0] exp_status(input logic [4:0] m, input bit pen, input bit hold_long);
    return {m[3], m[2], m[1], m[0] & pen & hold_long};
  endfunction

  task automatic run_case(input logic [4:0] m, input bit pen, input bit hold_long, input bit inject);
    logic [3:0] prev;
    bit started;
    int drv_n, rst_n;
    @(negedge clk);
    prev = status;
    pin_en = pen;
    ext_low = m[0];
    req_wdog = m[1]; req_illop = m[2]; req_clkfail = m[3]; req_dbg = m[4];
    started = (|m[4:1]) || (m[0] && pen);
    @(negedge clk);
    req_wdog = 0; req_illop = 0; req_clkfail = 0; req_dbg = 0;
    check("R2 start drive", pin_drive_low, started);
    check("R2 start core", core_rst, started);
    if (!started) begin
      repeat (3) @(negedge clk);
      check("R6 disabled pin no reset", core_rst, 1'b0);
      check("R6 disabled pin status", status, prev);
      ext_low = 0;
      return;
    end
    drv_n = 1; rst_n = 1;
    for (int c = 1; c < 200; c++) begin
      @(negedge clk);
      if (!core_rst) break;
      if (pin_drive_low) drv_n++;
      rst_n++;
      if (c == 10 && !hold_long) ext_low = 0;
      if (c == 20 && inject) begin
        req_wdog = 1; req_illop = 1; req_clkfail = 1; req_dbg = 1;
      end
      if (c == 21) begin
        req_wdog = 0; req_illop = 0; req_clkfail = 0; req_dbg = 0;
      end
      if (c == 40) check("R7 cleared and loaded at start", status, {m[3:1], 1'b0});
    end
    ext_low = 0;
    check("R3 drive length", drv_n, DRV);
    check("R4 reset length", rst_n, DRV + SET);
    check(m[4:1] == 4'b1000 ? "R8 debug-only status" : (inject ? "R9 status after injection" : "R5 R7 final status"),
          status, exp_status(m, pen, hold_long));
    prev = status;
    repeat (4) @(negedge clk);
    check("R10 idle status holds", status, prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset drive", pin_drive_low, 1'b0);
    check("R1 reset core", core_rst, 1'b0);
    arst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset status", status, 4'h0);

    run_case(5'b10000, 1, 0, 0);   // R8 debug only
    run_case(5'b00001, 1, 1, 0);   // R5 pin still low at sample
    run_case(5'b00010, 1, 0, 0);   // R7 pin bit cleared, wdog only
    run_case(5'b00001, 1, 0, 0);   // R5 pin released before sample
    run_case(5'b00001, 0, 1, 0);   // R6 disabled pin, no start
    run_case(5'b00101, 0, 1, 0);   // R6 illop with disabled pin held low
    run_case(5'b01111, 1, 1, 0);   // R7 all sources together
    run_case(5'b00100, 1, 0, 1);   // R9 injection mid-sequence
    run_case(5'b10000, 1, 0, 1);   // R8 R9 debug with injection

    for (int k = 0; k < 30; k++) begin
      logic [4:0] m;
      m = 5'($urandom % 32);
      run_case(m, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule